// File: doc/BRIEF.md
# Supervisor Execute and Access Guard

This block sits beside the memory request path of a processor and screens every translated request against two supervisor-mode protections. With the execute-prevention enable on, the most privileged level (level 0) may not fetch instructions from a page marked user-accessible. With the access-prevention enable on, level 0 may not read or write a user-accessible page unless an explicit access window is open. The window is a single flag held inside the block, opened by a set operation and closed by a clear operation.

Each valid request gets exactly one registered answer on the following cycle: either a grant, or a page-fault request with a cause code that tells an instruction-fetch violation apart from a data-access violation. Requests that pass are never held back, so back-to-back requests are answered back to back. The window flag can only be changed from level 0. An attempt from any other level is flagged as a privileged-operation violation and leaves the flag as it was. Reset and every trap entry close the window, so a handler never inherits an open window.

Top module: `sup_guard`

## Requirements
- R1: After a synchronous reset, grant, fault, op_viol and ac_flag are 0 and fault_cause is 0.
- R2: A valid request with kind 2'b00 (instruction fetch) at level 0 to a page with page_user=1, while ctrl_reg bit 20 is 1, produces fault=1 with fault_cause=2'b01 and grant=0 on the next cycle.
- R3: A valid request with kind 2'b01 (read) or 2'b10 (write) at level 0 to a page with page_user=1, while ctrl_reg bit 21 is 1 and ac_flag is 0, produces fault=1 with fault_cause=2'b10 and grant=0 on the next cycle. If ac_flag is 1, the request is granted.
- R4: When ctrl_reg bits 20 and 21 are both 0, every valid request at level 0 is granted, whatever its kind and whatever page_user is.
- R5: Valid requests at any level other than 0 are granted, whatever the two enables, page_user and ac_flag are.
- R6: At level 0, op_set_ac makes ac_flag 1 on the next cycle and op_clr_ac makes it 0 on the next cycle. If both are asserted together, the clear wins.
- R7: An op_set_ac or op_clr_ac at a level other than 0 raises op_viol for one cycle on the next cycle and leaves ac_flag unchanged. At level 0, op_viol stays 0.
- R8: trap_entry makes ac_flag 0 on the next cycle, overriding any set issued in the same cycle.
- R9: Every valid request is answered on the next cycle with no stall, including back-to-back requests. A cycle with req_valid=0 gives grant=0 and fault=0 on the next cycle. Requests to pages with page_user=0 are always granted.
- R10: grant and fault are never 1 together, and fault_cause is 2'b00 whenever fault is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_lvl | input | 2 | Current privilege level; 0 is the most privileged |
| req_valid | input | 1 | A memory request is present this cycle |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write |
| page_user | input | 1 | User-accessible bit of the translated page |
| ctrl_reg | input | 32 | Control register; bit 20 execute-prevention, bit 21 access-prevention |
| op_set_ac | input | 1 | Open the access window |
| op_clr_ac | input | 1 | Close the access window |
| trap_entry | input | 1 | A trap is being entered |
| grant | output | 1 | Request of the previous cycle is granted |
| fault | output | 1 | Request of the previous cycle raises a page fault |
| fault_cause | output | 2 | 01 fetch violation, 10 data violation, 00 none |
| op_viol | output | 1 | Previous-cycle window operation was attempted outside level 0 |
| ac_flag | output | 1 | Current state of the access window flag |

## Verification
Every result is registered once. A request, a window operation or a trap presented before a rising edge shows its effect on grant, fault, fault_cause, op_viol and ac_flag after that edge. The bench drives its inputs on the falling edge, lets one rising edge pass, and reads the outputs on the next falling edge. A request issued in the same cycle as a window operation is judged against the flag value from before that operation. For that reason the bench sets up the flag in separate cycles ahead of each sweep block, and the sweep then issues requests on consecutive cycles to show that there is no stall.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int KIND_W  = 2;
  localparam int CAUSE_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10
  } req_kind_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_FETCH = 2'b01,
    CAUSE_DATA  = 2'b10
  } fault_cause_e;
endpackage

// File: rtl/sg_rule.sv
module sg_rule
  import sg_pkg::*;
#(
  parameter int PRIV_W  = 2,
  parameter int SUP_LVL = 0
) (
  input  logic [PRIV_W-1:0]  priv_lvl,
  input  logic [KIND_W-1:0]  kind,
  input  logic               page_user,
  input  logic               xp_en,
  input  logic               ap_en,
  input  logic               ac,
  output logic               deny,
  output logic [CAUSE_W-1:0] cause
);
  logic is_sup;
  logic is_fetch;

  always_comb begin
    is_sup   = (priv_lvl == PRIV_W'(SUP_LVL));
    is_fetch = (kind == KIND_FETCH);
    deny     = 1'b0;
    cause    = CAUSE_NONE;
    if (is_sup && page_user) begin
      if (is_fetch) begin
        deny  = xp_en;
        cause = xp_en ? CAUSE_FETCH : CAUSE_NONE;
      end else begin
        deny  = ap_en && !ac;
        cause = (ap_en && !ac) ? CAUSE_DATA : CAUSE_NONE;
      end
    end
  end
endmodule

// File: rtl/sg_ac_flag.sv
module sg_ac_flag (
  input  logic clk,
  input  logic rst,
  input  logic trap_entry,
  input  logic set_req,
  input  logic clr_req,
  input  logic allowed,
  output logic flag,
  output logic viol
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst || trap_entry) begin
      flag_q <= 1'b0;
    end else if (allowed && clr_req) begin
      flag_q <= 1'b0;
    end else if (allowed && set_req) begin
      flag_q <= 1'b1;
    end
  end

  assign flag = flag_q;
  assign viol = (set_req || clr_req) && !allowed;
endmodule

// File: rtl/sup_guard.sv
module sup_guard
  import sg_pkg::*;
#(
  parameter int CTRL_W  = 32,
  parameter int XP_BIT  = 20,
  parameter int AP_BIT  = 21,
  parameter int PRIV_W  = 2,
  parameter int SUP_LVL = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRIV_W-1:0]  priv_lvl,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic               page_user,
  input  logic [CTRL_W-1:0]  ctrl_reg,
  input  logic               op_set_ac,
  input  logic               op_clr_ac,
  input  logic               trap_entry,
  output logic               grant,
  output logic               fault,
  output logic [1:0]         fault_cause,
  output logic               op_viol,
  output logic               ac_flag
);
  localparam logic [PRIV_W-1:0] SUP_CODE = PRIV_W'(SUP_LVL);

  logic               deny;
  logic [CAUSE_W-1:0] cause;
  logic               flag;
  logic               viol;
  logic               grant_q;
  logic               fault_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               viol_q;

  sg_rule #(.PRIV_W(PRIV_W), .SUP_LVL(SUP_LVL)) rule_i (
    .priv_lvl (priv_lvl),
    .kind     (req_kind),
    .page_user(page_user),
    .xp_en    (ctrl_reg[XP_BIT]),
    .ap_en    (ctrl_reg[AP_BIT]),
    .ac       (flag),
    .deny     (deny),
    .cause    (cause)
  );

  sg_ac_flag flag_i (
    .clk       (clk),
    .rst       (rst),
    .trap_entry(trap_entry),
    .set_req   (op_set_ac),
    .clr_req   (op_clr_ac),
    .allowed   (priv_lvl == SUP_CODE),
    .flag      (flag),
    .viol      (viol)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      viol_q  <= 1'b0;
    end else begin
      grant_q <= req_valid && !deny;
      fault_q <= req_valid && deny;
      cause_q <= (req_valid && deny) ? cause : CAUSE_NONE;
      viol_q  <= viol;
    end
  end

  assign grant       = grant_q;
  assign fault       = fault_q;
  assign fault_cause = cause_q;
  assign op_viol     = viol_q;
  assign ac_flag     = flag;
endmodule

// File: rtl/sup_guard_chk.sv
module sup_guard_chk #(
  parameter int CTRL_W = 32,
  parameter int XP_BIT = 20,
  parameter int AP_BIT = 21,
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [PRIV_W-1:0] priv_lvl,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              page_user,
  input logic [CTRL_W-1:0] ctrl_reg,
  input logic              op_set_ac,
  input logic              op_clr_ac,
  input logic              trap_entry,
  input logic              grant,
  input logic              fault,
  input logic [1:0]        fault_cause,
  input logic              op_viol,
  input logic              ac_flag
);
  assert_grant_fault_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(grant && fault));

  assert_cause_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !fault |-> fault_cause == 2'b00);

  assert_fetch_block_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b00 && priv_lvl == '0 && page_user && ctrl_reg[XP_BIT])
    |=> (fault && fault_cause == 2'b01 && !grant));

  assert_data_block_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != 2'b00 && priv_lvl == '0 && page_user && ctrl_reg[AP_BIT] && !ac_flag)
    |=> (fault && fault_cause == 2'b10));

  assert_user_level_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv_lvl != '0) |=> grant);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!grant && !fault));

  assert_op_viol_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ((op_set_ac || op_clr_ac) && priv_lvl != '0 && !trap_entry)
    |=> (op_viol && $stable(ac_flag)));

  assert_trap_close_R8: assert property (@(posedge clk) disable iff (rst)
    trap_entry |=> !ac_flag);
endmodule

bind sup_guard sup_guard_chk #(
  .CTRL_W(CTRL_W), .XP_BIT(XP_BIT), .AP_BIT(AP_BIT), .PRIV_W(PRIV_W)
) chk_i (.*);

// File: tb/sup_guard_tb_top.sv
module sup_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  priv_lvl = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        page_user = 1'b0;
  logic [31:0] ctrl_reg = '0;
  logic        op_set_ac = 1'b0;
  logic        op_clr_ac = 1'b0;
  logic        trap_entry = 1'b0;
  logic        grant, fault, op_viol, ac_flag;
  logic [1:0]  fault_cause;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sup_guard dut_i (
    .clk(clk), .rst(rst), .priv_lvl(priv_lvl), .req_valid(req_valid),
    .req_kind(req_kind), .page_user(page_user), .ctrl_reg(ctrl_reg),
    .op_set_ac(op_set_ac), .op_clr_ac(op_clr_ac), .trap_entry(trap_entry),
    .grant(grant), .fault(fault), .fault_cause(fault_cause),
    .op_viol(op_viol), .ac_flag(ac_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle with the given op inputs at level lvl; check the next state
  task automatic op_cycle(input logic [1:0] lvl, input logic s, input logic c, input logic t);
    priv_lvl = lvl; op_set_ac = s; op_clr_ac = c; trap_entry = t;
    @(posedge clk); @(negedge clk);
    op_set_ac = 1'b0; op_clr_ac = 1'b0; trap_entry = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 grant", grant, 0);
    chk("R1 fault", fault, 0);
    chk("R1 cause", fault_cause, 0);
    chk("R1 op_viol", op_viol, 0);
    chk("R1 ac_flag", ac_flag, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle grant", grant, 0);
    chk("R9 idle fault", fault, 0);

    // R6 set/clear at level 0
    op_cycle(2'd0, 1, 0, 0);
    chk("R6 set", ac_flag, 1);
    chk("R7 op_viol at level 0", op_viol, 0);
    op_cycle(2'd0, 1, 1, 0);
    chk("R6 clear wins", ac_flag, 0);
    op_cycle(2'd0, 1, 0, 0);
    op_cycle(2'd0, 0, 1, 0);
    chk("R6 clear", ac_flag, 0);
    // R7 ops outside level 0
    op_cycle(2'd3, 1, 0, 0);
    chk("R7 set ignored", ac_flag, 0);
    chk("R7 op_viol set", op_viol, 1);
    op_cycle(2'd0, 1, 0, 0);
    op_cycle(2'd1, 0, 1, 0);
    chk("R7 clear ignored", ac_flag, 1);
    chk("R7 op_viol clear", op_viol, 1);
    @(negedge clk);
    chk("R7 op_viol one cycle", op_viol, 0);
    // R8 trap entry
    op_cycle(2'd0, 0, 0, 1);
    chk("R8 trap clears", ac_flag, 0);
    op_cycle(2'd0, 1, 0, 1);
    chk("R8 trap beats set", ac_flag, 0);

    // exhaustive request sweep, back-to-back within each flag setting
    for (int ac = 0; ac < 2; ac++) begin
      if (ac == 1) op_cycle(2'd0, 1, 0, 0);
      chk("R6 flag for sweep", ac_flag, ac);
      for (int lv = 0; lv < 4; lv++)
        for (int k = 0; k < 3; k++)
          for (int u = 0; u < 2; u++)
            for (int en = 0; en < 4; en++) begin
              logic xp, ap, dny;
              int   ecause;
              xp = en[0]; ap = en[1];
              priv_lvl  = lv[1:0];
              req_kind  = k[1:0];
              page_user = u[0];
              ctrl_reg  = '0;
              ctrl_reg[20] = xp;
              ctrl_reg[21] = ap;
              req_valid = 1'b1;
              dny = 1'b0; ecause = 0;
              if (lv == 0 && u == 1) begin
                if (k == 0) begin dny = xp; ecause = xp ? 1 : 0; end
                else begin dny = ap && (ac == 0); ecause = dny ? 2 : 0; end
              end
              @(posedge clk); @(negedge clk);
              if (lv != 0)      chk("R5 grant", grant, 1);
              else if (u == 0)  chk("R9 sup page grant", grant, 1);
              else if (en == 0) chk("R4 grant", grant, 1);
              else if (k == 0)  chk("R2 grant", grant, !dny);
              else              chk("R3 grant", grant, !dny);
              if (k == 0) chk("R2 fault", fault, dny);
              else        chk("R3 fault", fault, dny);
              chk("R10 cause", fault_cause, ecause);
              chk("R10 exclusive", grant & fault, 0);
            end
      req_valid = 1'b0;
      @(negedge clk);
      chk("R9 idle after burst", grant | fault, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule